// File: doc/BRIEF.md
# Power Mode Sequencer

This block is the top-level mode controller of a lighting and power management chip. It decides which operating mode the chip is in and drives the enables for the analog blocks that the mode needs. The modes are hard reset, low-power standby, internal startup, boost soft-start and normal operation. The reference, bias and oscillator are not modelled here, and neither is the boost converter. Each of them appears only as an enable or mode-select output.

The inputs are an external active-low reset, a power-on-reset flag, a thermal-shutdown flag, and two register-derived levels. One level says whether the chip should be awake; the other asks for the boost converter. A one-cycle millisecond tick from a slow timebase times the two fixed waits: the internal startup wait, then the boost soft-start wait. The parameter `DELAY_TICKS` sets the length of each wait, and simulation can shorten it.

The block is used as follows. Software or board logic drives the level inputs. The sequencer walks the chip through its modes and reports the current mode on a three-bit code. A thermal event at any time sends the chip back to startup, where it starts the wait again. The boost converter can be switched off and on again in normal operation. Each time it is switched on, it repeats its soft-start.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `srst` is high, `ext_rst_n` is low or `por_active` is high, the next clock edge puts the mode code at 0 (reset) with all five enable outputs low. This overrides every other input in every mode.
- R2: From reset the block always moves to standby (code 1) on the next edge. It stays in standby while `stby_n` is low, and all five enable outputs are low there.
- R3: In standby with `stby_n` high, the next edge enters internal startup (code 2). In startup `ref_en` and `osc_en` are high, and `core_ready`, `boost_en` and `boost_pwm` are low.
- R4: Internal startup ends on the edge that samples the `DELAY_TICKS`-th `ms_tick` counted while in startup. It goes to boost soft-start (code 3) if `boost_req` is high and to normal (code 4) otherwise. One tick fewer leaves it in startup.
- R5: `thermal_fault` high in startup, boost soft-start or normal gives code 2 on the next edge. While the fault stays high the startup count is held at zero. After the fault clears, a full `DELAY_TICKS` ticks are needed again.
- R6: In boost soft-start `boost_en` is high and `boost_pwm` is low (PFM). After `DELAY_TICKS` ticks in that mode the block enters normal with `boost_en` and `boost_pwm` both high (PWM).
- R7: In normal mode with the boost running, `boost_req` low turns `boost_en` and `boost_pwm` off on the next edge. The mode stays at code 4 and `ref_en`, `osc_en` and `core_ready` stay high.
- R8: In normal mode with the boost off, `boost_req` high gives code 3 on the next edge, so the soft-start is repeated.
- R9: `stby_n` low in startup, boost soft-start or normal gives code 1 on the next edge. This takes priority over `thermal_fault`.
- R10: `ms_tick` has no effect outside startup and boost soft-start. Ticks seen in standby or normal do not shorten a later wait and do not change the mode or the outputs.
- R11: `core_ready` is high only in normal mode (code 4).
- R12: `boost_req` low during boost soft-start gives normal mode on the next edge, with `boost_en` and `boost_pwm` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| srst | input | 1 | Synchronous active-high reset |
| ext_rst_n | input | 1 | External reset, active low |
| por_active | input | 1 | Power-on reset flag |
| thermal_fault | input | 1 | Thermal shutdown flag |
| stby_n | input | 1 | Wake request; low selects standby |
| boost_req | input | 1 | Boost converter enable request |
| ms_tick | input | 1 | One-cycle millisecond tick |
| ref_en | output | 1 | Reference and bias enable |
| osc_en | output | 1 | Oscillator enable |
| core_ready | output | 1 | Chip core in normal operation |
| boost_en | output | 1 | Boost converter enable |
| boost_pwm | output | 1 | Boost mode select: 1 PWM, 0 PFM |
| mode_code | output | 3 | Mode: 0 reset, 1 standby, 2 startup, 3 boost soft-start, 4 normal |

## Verification
The hardest situation to reach is a thermal fault that hits part-way through a wait. The bench has to show that the wait restarts from zero rather than resuming, and that a fault during the boost soft-start or normal mode falls back to the startup wait. The bench brings each running mode up from reset with a known number of ticks, applies a partial tick count, and raises the fault while ticks keep arriving. It then sweeps the ticks after the fault clears, one short of the wait and then exactly the wait. It also sweeps every tick count from zero to the full wait, with the boost request both ways, and checks the mode reached at each count.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [2:0] {
        MS_RESET    = 3'd0,
        MS_STANDBY  = 3'd1,
        MS_STARTUP  = 3'd2,
        MS_BOOST_SS = 3'd3,
        MS_NORMAL   = 3'd4
    } pm_mode_e;

    typedef struct packed {
        logic ref_en;
        logic osc_en;
        logic core_ready;
        logic boost_en;
        logic boost_pwm;
    } pm_out_s;

    localparam pm_out_s PM_ALL_OFF = '0;

    // Modes in which the chip core is powered and a wake request is honoured
    function automatic logic is_running(pm_mode_e m);
        return (m == MS_STARTUP) || (m == MS_BOOST_SS) || (m == MS_NORMAL);
    endfunction

    // Modes that consume millisecond ticks
    function automatic logic is_timed(pm_mode_e m);
        return (m == MS_STARTUP) || (m == MS_BOOST_SS);
    endfunction

endpackage

// File: rtl/pms_delay_timer.sv
module pms_delay_timer #(
    parameter int DELAY_TICKS = 10
) (
    input  logic clk,
    input  logic srst,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(DELAY_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (srst || clr) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The wait ends on the tick that completes DELAY_TICKS
    assign done = run && tick && (cnt == LAST);

endmodule

// File: rtl/pms_state_ctl.sv
module pms_state_ctl
    import pms_pkg::*;
(
    input  logic     clk,
    input  logic     srst,
    input  logic     hard_rst,
    input  logic     stby_n,
    input  logic     thermal,
    input  logic     boost_req,
    input  logic     tmr_done,
    output pm_mode_e mode,
    output logic     boost_run,
    output logic     tmr_clr,
    output logic     tmr_run
);
    pm_mode_e nxt;
    logic     boost_nxt;

    always_comb begin
        nxt       = mode;
        boost_nxt = boost_run;
        if (hard_rst) begin
            nxt = MS_RESET;
        end else if (mode == MS_RESET) begin
            nxt = MS_STANDBY;
        end else if (mode == MS_STANDBY) begin
            if (stby_n) nxt = MS_STARTUP;
        end else if (!stby_n) begin
            nxt = MS_STANDBY;
        end else if (thermal) begin
            nxt = MS_STARTUP;
        end else begin
            unique case (mode)
                MS_STARTUP: begin
                    if (tmr_done) nxt = boost_req ? MS_BOOST_SS : MS_NORMAL;
                end
                MS_BOOST_SS: begin
                    if (!boost_req) begin
                        nxt = MS_NORMAL;
                    end else if (tmr_done) begin
                        nxt       = MS_NORMAL;
                        boost_nxt = 1'b1;
                    end
                end
                MS_NORMAL: begin
                    if (!boost_req)      boost_nxt = 1'b0;
                    else if (!boost_run) nxt = MS_BOOST_SS;
                end
                default: nxt = MS_RESET;
            endcase
        end
        if (nxt != MS_NORMAL) boost_nxt = 1'b0;
    end

    assign tmr_clr = (nxt != mode) || ((mode == MS_STARTUP) && thermal);
    assign tmr_run = is_timed(mode);

    always_ff @(posedge clk) begin
        if (srst) begin
            mode      <= MS_RESET;
            boost_run <= 1'b0;
        end else begin
            mode      <= nxt;
            boost_run <= boost_nxt;
        end
    end

endmodule

// File: rtl/pms_out_map.sv
module pms_out_map
    import pms_pkg::*;
(
    input  pm_mode_e mode,
    input  logic     boost_run,
    output pm_out_s  outs
);
    always_comb begin
        outs = PM_ALL_OFF;
        unique case (mode)
            MS_STARTUP: begin
                outs.ref_en = 1'b1;
                outs.osc_en = 1'b1;
            end
            MS_BOOST_SS: begin
                outs.ref_en   = 1'b1;
                outs.osc_en   = 1'b1;
                outs.boost_en = 1'b1;
            end
            MS_NORMAL: begin
                outs.ref_en     = 1'b1;
                outs.osc_en     = 1'b1;
                outs.core_ready = 1'b1;
                outs.boost_en   = boost_run;
                outs.boost_pwm  = boost_run;
            end
            default: outs = PM_ALL_OFF;
        endcase
    end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int DELAY_TICKS = 10
) (
    input  logic       clk,
    input  logic       srst,
    input  logic       ext_rst_n,
    input  logic       por_active,
    input  logic       thermal_fault,
    input  logic       stby_n,
    input  logic       boost_req,
    input  logic       ms_tick,
    output logic       ref_en,
    output logic       osc_en,
    output logic       core_ready,
    output logic       boost_en,
    output logic       boost_pwm,
    output logic [2:0] mode_code
);
    pm_mode_e mode;
    pm_out_s  outs;
    logic     boost_run;
    logic     tmr_clr;
    logic     tmr_run;
    logic     tmr_done;

    pms_delay_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
        .clk  (clk),
        .srst (srst),
        .clr  (tmr_clr),
        .run  (tmr_run),
        .tick (ms_tick),
        .done (tmr_done)
    );

    pms_state_ctl u_ctl (
        .clk       (clk),
        .srst      (srst),
        .hard_rst  (!ext_rst_n || por_active),
        .stby_n    (stby_n),
        .thermal   (thermal_fault),
        .boost_req (boost_req),
        .tmr_done  (tmr_done),
        .mode      (mode),
        .boost_run (boost_run),
        .tmr_clr   (tmr_clr),
        .tmr_run   (tmr_run)
    );

    pms_out_map u_map (
        .mode      (mode),
        .boost_run (boost_run),
        .outs      (outs)
    );

    assign ref_en     = outs.ref_en;
    assign osc_en     = outs.osc_en;
    assign core_ready = outs.core_ready;
    assign boost_en   = outs.boost_en;
    assign boost_pwm  = outs.boost_pwm;
    assign mode_code  = mode;

endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
    parameter int DELAY_TICKS = 10
) (
    input logic       clk,
    input logic       srst,
    input logic       ext_rst_n,
    input logic       por_active,
    input logic       thermal_fault,
    input logic       stby_n,
    input logic       boost_req,
    input logic       ms_tick,
    input logic       ref_en,
    input logic       osc_en,
    input logic       core_ready,
    input logic       boost_en,
    input logic       boost_pwm,
    input logic [2:0] mode_code
);
    localparam int CW = $clog2(DELAY_TICKS + 2);

    logic          quiet;
    logic          running;
    logic [CW-1:0] st_cnt;

    assign quiet   = ext_rst_n && !por_active;
    assign running = (mode_code == 3'd2) || (mode_code == 3'd3) || (mode_code == 3'd4);

    // Independent count of ticks seen in startup since the last entry or fault
    always_ff @(posedge clk) begin
        if (srst || (mode_code != 3'd2) || thermal_fault) st_cnt <= '0;
        else if (ms_tick) st_cnt <= st_cnt + 1'b1;
    end

    AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (srst)
        !quiet |=> (mode_code == 3'd0)); // R1

    AST_STBY_QUIET: assert property (@(posedge clk) disable iff (srst)
        (mode_code == 3'd1) |-> !(ref_en || osc_en || core_ready || boost_en || boost_pwm)); // R2

    AST_STARTUP_LEN: assert property (@(posedge clk) disable iff (srst)
        (($past(mode_code) == 3'd2) && ((mode_code == 3'd3) || (mode_code == 3'd4)))
        |-> (st_cnt == CW'(DELAY_TICKS))); // R4

    AST_THERM_BACK: assert property (@(posedge clk) disable iff (srst)
        (quiet && stby_n && thermal_fault && running) |=> (mode_code == 3'd2)); // R5

    AST_SOFT_PFM: assert property (@(posedge clk) disable iff (srst)
        (mode_code == 3'd3) |-> (boost_en && !boost_pwm)); // R6

    AST_BOOST_DROP: assert property (@(posedge clk) disable iff (srst)
        (quiet && stby_n && !thermal_fault && (mode_code == 3'd4) && !boost_req)
        |=> (!boost_en && !boost_pwm && (mode_code == 3'd4))); // R7

    AST_BOOST_RESTART: assert property (@(posedge clk) disable iff (srst)
        (quiet && stby_n && !thermal_fault && (mode_code == 3'd4) && boost_req && !boost_en)
        |=> (mode_code == 3'd3)); // R8

    AST_STBY_ENTRY: assert property (@(posedge clk) disable iff (srst)
        (quiet && !stby_n && running) |=> (mode_code == 3'd1)); // R9

    AST_READY_NORMAL: assert property (@(posedge clk) disable iff (srst)
        core_ready |-> (mode_code == 3'd4)); // R11

endmodule

bind pwr_mode_seq pms_checker #(.DELAY_TICKS(DELAY_TICKS)) u_pms_checker (
    .clk           (clk),
    .srst          (srst),
    .ext_rst_n     (ext_rst_n),
    .por_active    (por_active),
    .thermal_fault (thermal_fault),
    .stby_n        (stby_n),
    .boost_req     (boost_req),
    .ms_tick       (ms_tick),
    .ref_en        (ref_en),
    .osc_en        (osc_en),
    .core_ready    (core_ready),
    .boost_en      (boost_en),
    .boost_pwm     (boost_pwm),
    .mode_code     (mode_code)
);

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;
    localparam int D = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic srst = 1'b1, ext_rst_n = 1'b1, por_active = 1'b0, thermal_fault = 1'b0;
    logic stby_n = 1'b0, boost_req = 1'b0, ms_tick = 1'b0;
    logic ref_en, osc_en, core_ready, boost_en, boost_pwm;
    logic [2:0] mode_code;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    pwr_mode_seq #(.DELAY_TICKS(D)) u_pwr_mode_seq (
        .clk(clk), .srst(srst), .ext_rst_n(ext_rst_n), .por_active(por_active),
        .thermal_fault(thermal_fault), .stby_n(stby_n), .boost_req(boost_req),
        .ms_tick(ms_tick), .ref_en(ref_en), .osc_en(osc_en), .core_ready(core_ready),
        .boost_en(boost_en), .boost_pwm(boost_pwm), .mode_code(mode_code)
    );

    function automatic logic [7:0] outs();
        return {3'b000, ref_en, osc_en, core_ready, boost_en, boost_pwm};
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic chk_mode(input string tag, input int exp);
        chk(tag, {5'b0, mode_code}, 8'(exp));
    endtask

    task automatic step(input bit t);
        ms_tick = t;
        @(posedge clk);
        #1;
        ms_tick = 1'b0;
    endtask

    // Bring the block from reset to startup, soft-start or normal
    task automatic reach(input int tgt, input bit boost);
        srst = 1'b1; ext_rst_n = 1'b1; por_active = 1'b0; thermal_fault = 1'b0;
        stby_n = 1'b1; boost_req = boost;
        step(0);
        srst = 1'b0;
        step(0);
        step(0);
        if (tgt >= 3) repeat (D) step(1);
        if (tgt == 4 && boost) repeat (D) step(1);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all R): actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        step(0);
        step(0);
        chk_mode("R1 reset mode", 0);
        chk("R1 reset outputs", outs(), 8'h00);
        srst = 1'b0;
        step(0);
        chk_mode("R2 reset to standby", 1);
        repeat (5) step(1);
        chk_mode("R2 R10 standby holds under ticks", 1);
        chk("R2 standby outputs", outs(), 8'h00);
        stby_n = 1'b1;
        step(0);
        chk_mode("R3 wake to startup", 2);
        chk("R3 startup outputs", outs(), 8'h18);
        repeat (D - 1) step(1);
        chk_mode("R10 standby ticks not counted", 2);

        // R4 sweep over tick counts and boost request, ticks spaced by idle cycles
        for (int b = 0; b < 2; b++) begin
            for (int k = 0; k <= D; k++) begin
                reach(2, b[0]);
                for (int i = 0; i < k; i++) begin
                    step(1);
                    step(0);
                end
                chk_mode("R4 startup length", (k < D) ? 2 : (b == 1 ? 3 : 4));
            end
        end

        // R5 thermal fault from each running mode
        for (int s = 2; s <= 4; s++) begin
            reach(s, s == 3);
            if (s == 2) step(1);
            thermal_fault = 1'b1;
            repeat (2) step(1);
            chk_mode("R5 fault to startup", 2);
            chk("R5 fault outputs", outs(), 8'h18);
            thermal_fault = 1'b0;
            repeat (D - 1) step(1);
            chk_mode("R5 wait restarted", 2);
            step(1);
            chk_mode("R5 wait complete", (s == 3) ? 3 : 4);
        end

        // Boost soft-start, normal, drop and restart
        reach(3, 1'b1);
        chk_mode("R6 soft-start mode", 3);
        chk("R6 R11 soft-start PFM outputs", outs(), 8'h1A);
        repeat (D - 1) step(1);
        chk_mode("R6 soft-start length", 3);
        step(1);
        chk_mode("R6 soft-start done", 4);
        chk("R6 R11 PWM outputs in normal", outs(), 8'h1F);
        repeat (4) step(1);
        chk("R10 ticks in normal ignored", {outs()[4:0], mode_code}, {outs()[4:0], 3'd4});
        chk("R10 normal outputs after ticks", outs(), 8'h1F);
        boost_req = 1'b0;
        step(0);
        chk_mode("R7 boost off keeps normal", 4);
        chk("R7 boost off outputs", outs(), 8'h1C);
        boost_req = 1'b1;
        step(0);
        chk_mode("R8 boost soft-start again", 3);
        chk("R8 soft-start outputs", outs(), 8'h1A);
        boost_req = 1'b0;
        step(0);
        chk_mode("R12 abort soft-start", 4);
        chk("R12 abort outputs", outs(), 8'h1C);

        // R9 standby request wins over a thermal fault
        for (int s = 2; s <= 4; s++) begin
            reach(s, s == 3);
            thermal_fault = 1'b1;
            stby_n = 1'b0;
            step(0);
            chk_mode("R9 standby from running", 1);
            chk("R9 standby outputs", outs(), 8'h00);
            thermal_fault = 1'b0;
        end

        // R1 overrides
        reach(4, 1'b1);
        ext_rst_n = 1'b0;
        stby_n = 1'b0;
        step(0);
        chk_mode("R1 external reset in normal", 0);
        chk("R1 external reset outputs", outs(), 8'h00);
        ext_rst_n = 1'b1;
        stby_n = 1'b1;
        step(0);
        chk_mode("R2 reset exits to standby", 1);
        step(0);
        chk_mode("R3 standby to startup", 2);
        reach(2, 1'b0);
        por_active = 1'b1;
        step(1);
        chk_mode("R1 power-on reset in startup", 0);
        step(1);
        chk_mode("R1 power-on reset held", 0);
        por_active = 1'b0;
        reach(3, 1'b1);
        thermal_fault = 1'b1;
        por_active = 1'b1;
        step(0);
        chk_mode("R1 reset over fault", 0);
        por_active = 1'b0;
        thermal_fault = 1'b0;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule